// File: doc/BRIEF.md
# Masked Vector Move Execution Unit

This unit carries out one aligned move of packed 32-bit single-precision values per request, on a vector of at most 512 bits. A request supplies the source vector, the present destination contents, the address of the memory operand (when one is used), a 16-bit element mask with a flag that turns masking off, a select between zeroing and merging, the vector length, the form of the move and the encoding class. For a store, the destination input holds the current memory image and the unit returns the merged image with a byte enable for each written byte. For loads and register copies, the unit returns the full new 512-bit register value.

The values pass through unchanged, bit for bit. No floating-point exception exists. The unit checks that a memory operand sits on a boundary equal to its own size and that the reserved 4-bit register-specifier field is all ones. A fault of either kind suppresses the write. Every result is registered and appears one clock after the request strobe, and a new request may be issued on every cycle.

Top module: `vmove_unit`

## Requirements
- R1: The element count follows from the length code `req_vlen` (0 = 128 bits / 4 elements, 1 = 256 bits / 8 elements, 2 = 512 bits / 16 elements). Element j occupies bits [32j+31:32j]. No element at or above the count is ever store-enabled.
- R2: An element below the count takes the source value when its mask bit is set or when masking is off (`req_nomask` = 1).
- R3: The form code `req_form` is 0 for load, 1 for store and 2 for register copy. With masking in force on a load or copy, an unselected element keeps the destination value when `req_zero` = 0 and becomes zero when `req_zero` = 1.
- R4: On a store, `rsp_byte_en` is high on exactly the four bytes of each selected element, and unselected lanes keep the destination value whatever `req_zero` holds. Loads and copies drive no byte enables.
- R5: The encoding code `req_enc` is 0 for legacy, 1 for VEX-style and 2 for EVEX-style. For codes 1 and 2, a load or copy clears result bits from the vector length up to bit 511.
- R6: A legacy load or copy keeps result bits 511:128 equal to the destination input.
- R7: A load or store whose address is not a multiple of the operand size (16, 32 or 64 bytes) sets `rsp_gp`. A register copy never sets it.
- R8: For encodings 1 and 2, a reserved field other than 4'b1111 sets `rsp_ud`. Legacy requests ignore the field.
- R9: Values are copied bit-exactly, including NaN payloads and denormals.
- R10: Legacy and VEX-style requests ignore the mask inputs. Any of the following sets `rsp_ud`: a 512-bit length on a non-EVEX encoding, a legacy length other than 128, or a code value of 3 in any field.
- R11: Each request strobe gives `rsp_valid` high on the next clock with the registered result. A cycle with no strobe gives `rsp_valid` low on the next clock.
- R12: A faulted response has zero byte enables and data equal to the destination input. When both faults apply, only `rsp_ud` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| req_src | input | 512 | Source vector |
| req_dst | input | 512 | Current destination register or memory image |
| req_addr | input | 32 | Byte address of the memory operand |
| req_mask | input | 16 | Per-element mask |
| req_nomask | input | 1 | Masking off |
| req_zero | input | 1 | 1 = zeroing, 0 = merging |
| req_vlen | input | 2 | Length code |
| req_form | input | 2 | Form code |
| req_enc | input | 2 | Encoding class code |
| req_rsvd | input | 4 | Reserved register-specifier field |
| rsp_valid | output | 1 | Result valid |
| rsp_data | output | 512 | Result vector |
| rsp_byte_en | output | 64 | Per-byte store enable |
| rsp_gp | output | 1 | Alignment (general-protection) fault |
| rsp_ud | output | 1 | Undefined-opcode fault |

## Verification
The reserved-field check and the alignment check can both trip on one request: a VEX-style or EVEX-style load or store that carries a bad reserved field and also a misaligned address. The sweep crosses misaligned addresses with both legal and illegal reserved values over every length, form and encoding, so the overlap comes up many times. Each such response must show only the undefined-opcode flag, with no byte enables and the destination returned unchanged.

// File: rtl/vmove_pkg.sv
package vmove_pkg;

    typedef enum logic [1:0] {
        VL_128 = 2'd0,
        VL_256 = 2'd1,
        VL_512 = 2'd2
    } vlen_e;

    typedef enum logic [1:0] {
        FORM_LOAD  = 2'd0,
        FORM_STORE = 2'd1,
        FORM_COPY  = 2'd2
    } form_e;

    typedef enum logic [1:0] {
        ENC_LEGACY = 2'd0,
        ENC_VEX    = 2'd1,
        ENC_EVEX   = 2'd2
    } enc_e;

endpackage

// File: rtl/vmove_fault_chk.sv
module vmove_fault_chk
    import vmove_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int RSVD_W    = 4,
    parameter int MIN_BYTES = 16
) (
    input  logic [1:0]        vlen_i,
    input  logic [1:0]        form_i,
    input  logic [1:0]        enc_i,
    input  logic [RSVD_W-1:0] rsvd_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              gp_o,
    output logic              ud_o
);

    logic [ADDR_W-1:0] span;
    logic              rsvd_bad;
    logic              len_bad;
    logic              code_bad;
    logic              has_mem;
    logic              misaligned;

    always_comb begin
        span       = ADDR_W'(MIN_BYTES) << vlen_i;
        rsvd_bad   = (enc_i != ENC_LEGACY) && (rsvd_i != {RSVD_W{1'b1}});
        len_bad    = (vlen_i == 2'd3)
                   || ((enc_i == ENC_LEGACY) && (vlen_i != VL_128))
                   || ((enc_i == ENC_VEX) && (vlen_i == VL_512));
        code_bad   = (form_i == 2'd3) || (enc_i == 2'd3);
        has_mem    = (form_i == FORM_LOAD) || (form_i == FORM_STORE);
        misaligned = has_mem && (|(addr_i & (span - ADDR_W'(1))));
        ud_o       = rsvd_bad || len_bad || code_bad;
        gp_o       = !ud_o && misaligned;
    end

endmodule

// File: rtl/vmove_lane.sv
module vmove_lane #(
    parameter int ELEM_W    = 32,
    parameter int LANE_IDX  = 0,
    parameter int MIN_ELEMS = 4
) (
    input  logic [ELEM_W-1:0] src_i,
    input  logic [ELEM_W-1:0] dst_i,
    input  logic              mask_bit_i,
    input  logic              use_mask_i,
    input  logic              zero_i,
    input  logic              is_store_i,
    input  logic              keep_upper_i,
    input  logic [1:0]        vlen_i,
    output logic [ELEM_W-1:0] res_o,
    output logic              wr_en_o
);

    int   lim;
    logic in_vl;
    logic sel;

    always_comb begin
        lim     = MIN_ELEMS << vlen_i;
        in_vl   = LANE_IDX < lim;
        sel     = !use_mask_i || mask_bit_i;
        res_o   = dst_i;
        wr_en_o = 1'b0;
        if (in_vl) begin
            if (sel) begin
                res_o   = src_i;
                wr_en_o = is_store_i;
            end else if (!is_store_i && use_mask_i && zero_i) begin
                res_o = '0;
            end
        end else if (!is_store_i && !keep_upper_i) begin
            res_o = '0;
        end
    end

endmodule

// File: rtl/vmove_unit.sv
module vmove_unit
    import vmove_pkg::*;
#(
    parameter int ELEM_W    = 32,
    parameter int MAX_ELEMS = 16,
    parameter int MIN_ELEMS = 4,
    parameter int ADDR_W    = 32,
    parameter int RSVD_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [ELEM_W*MAX_ELEMS-1:0] req_src,
    input  logic [ELEM_W*MAX_ELEMS-1:0] req_dst,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [MAX_ELEMS-1:0]        req_mask,
    input  logic                        req_nomask,
    input  logic                        req_zero,
    input  logic [1:0]                  req_vlen,
    input  logic [1:0]                  req_form,
    input  logic [1:0]                  req_enc,
    input  logic [RSVD_W-1:0]           req_rsvd,
    output logic                        rsp_valid,
    output logic [ELEM_W*MAX_ELEMS-1:0] rsp_data,
    output logic [ELEM_W*MAX_ELEMS/8-1:0] rsp_byte_en,
    output logic                        rsp_gp,
    output logic                        rsp_ud
);

    localparam int VEC_W      = ELEM_W * MAX_ELEMS;
    localparam int BYTE_LANES = VEC_W / 8;
    localparam int ELEM_BYTES = ELEM_W / 8;
    localparam int MIN_BYTES  = MIN_ELEMS * ELEM_BYTES;

    typedef struct packed {
        logic                  valid;
        logic [VEC_W-1:0]      data;
        logic [BYTE_LANES-1:0] be;
        logic                  gp;
        logic                  ud;
    } rsp_t;

    rsp_t state_d, state_q;

    logic                 use_mask;
    logic                 is_store;
    logic                 keep_upper;
    logic [VEC_W-1:0]     lane_vec;
    logic [MAX_ELEMS-1:0] lane_wr;
    logic                 gp_w;
    logic                 ud_w;

    assign use_mask   = (req_enc == ENC_EVEX) && !req_nomask;
    assign is_store   = (req_form == FORM_STORE);
    assign keep_upper = (req_enc == ENC_LEGACY);

    vmove_fault_chk #(
        .ADDR_W   (ADDR_W),
        .RSVD_W   (RSVD_W),
        .MIN_BYTES(MIN_BYTES)
    ) fault_i (
        .vlen_i(req_vlen),
        .form_i(req_form),
        .enc_i (req_enc),
        .rsvd_i(req_rsvd),
        .addr_i(req_addr),
        .gp_o  (gp_w),
        .ud_o  (ud_w)
    );

    for (genvar j = 0; j < MAX_ELEMS; j++) begin : g_lane
        vmove_lane #(
            .ELEM_W   (ELEM_W),
            .LANE_IDX (j),
            .MIN_ELEMS(MIN_ELEMS)
        ) lane_i (
            .src_i       (req_src[j*ELEM_W +: ELEM_W]),
            .dst_i       (req_dst[j*ELEM_W +: ELEM_W]),
            .mask_bit_i  (req_mask[j]),
            .use_mask_i  (use_mask),
            .zero_i      (req_zero),
            .is_store_i  (is_store),
            .keep_upper_i(keep_upper),
            .vlen_i      (req_vlen),
            .res_o       (lane_vec[j*ELEM_W +: ELEM_W]),
            .wr_en_o     (lane_wr[j])
        );
    end

    always_comb begin
        state_d       = state_q;
        state_d.valid = req_valid;
        if (req_valid) begin
            state_d.gp = gp_w;
            state_d.ud = ud_w;
            if (gp_w || ud_w) begin
                state_d.data = req_dst;
                state_d.be   = '0;
            end else begin
                state_d.data = lane_vec;
                for (int b = 0; b < BYTE_LANES; b++) begin
                    state_d.be[b] = lane_wr[b / ELEM_BYTES];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid   = state_q.valid;
    assign rsp_data    = state_q.data;
    assign rsp_byte_en = state_q.be;
    assign rsp_gp      = state_q.gp;
    assign rsp_ud      = state_q.ud;

    p_strobe_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_idle_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_fault_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_gp && rsp_ud));

    p_fault_nowrite_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_gp || rsp_ud)) |-> (rsp_byte_en == '0));

    p_copy_nogp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_form == FORM_COPY) |=> !rsp_gp);

    p_rsvd_ud_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_enc != ENC_LEGACY && req_rsvd != {RSVD_W{1'b1}}) |=> rsp_ud);

    p_noenable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_form != FORM_STORE) |=> (rsp_byte_en == '0));

    p_short_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_vlen == VL_128) |=> (rsp_byte_en[BYTE_LANES-1:MIN_BYTES] == '0));

    p_legacy_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_enc == ENC_LEGACY)
        |=> (rsp_data[VEC_W-1:MIN_ELEMS*ELEM_W] == $past(req_dst[VEC_W-1:MIN_ELEMS*ELEM_W])));

endmodule

// File: tb/vmove_unit_tb.sv
`timescale 1ns/1ps
module vmove_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [511:0] req_src = '0;
    logic [511:0] req_dst = '0;
    logic [31:0]  req_addr = '0;
    logic [15:0]  req_mask = '0;
    logic         req_nomask = 1'b0;
    logic         req_zero = 1'b0;
    logic [1:0]   req_vlen = '0;
    logic [1:0]   req_form = '0;
    logic [1:0]   req_enc = '0;
    logic [3:0]   req_rsvd = '0;
    logic         rsp_valid;
    logic [511:0] rsp_data;
    logic [63:0]  rsp_byte_en;
    logic         rsp_gp;
    logic         rsp_ud;

    int tests = 0;
    int fails = 0;

    logic [511:0] exp_data;
    logic [63:0]  exp_be;
    logic         exp_gp;
    logic         exp_ud;
    logic         pend = 1'b0;
    string        pend_tag;

    always #4 clk = ~clk;

    vmove_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_src    (req_src),
        .req_dst    (req_dst),
        .req_addr   (req_addr),
        .req_mask   (req_mask),
        .req_nomask (req_nomask),
        .req_zero   (req_zero),
        .req_vlen   (req_vlen),
        .req_form   (req_form),
        .req_enc    (req_enc),
        .req_rsvd   (req_rsvd),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .rsp_byte_en(rsp_byte_en),
        .rsp_gp     (rsp_gp),
        .rsp_ud     (rsp_ud)
    );

    function automatic logic [511:0] mkvec(input logic [31:0] seed);
        logic [511:0] v;
        for (int j = 0; j < 16; j++) begin
            v[j*32 +: 32] = seed ^ (32'h0101_0101 * j) ^ 32'h7FC0_0001;
        end
        return v;
    endfunction

    task automatic model(input logic [511:0] s, input logic [511:0] d, input logic [31:0] a,
                         input logic [15:0] m, input logic nm, input logic z,
                         input logic [1:0] vl, input logic [1:0] fm, input logic [1:0] en,
                         input logic [3:0] rs);
        int   n;
        logic um;
        logic sel;
        n = (vl == 2'd0) ? 4 : (vl == 2'd1) ? 8 : 16;
        exp_ud = (fm == 2'd3) || (en == 2'd3) || (vl == 2'd3) || (en != 2'd0 && rs != 4'hF)
              || (en == 2'd0 && vl != 2'd0) || (en == 2'd1 && vl == 2'd2);
        exp_gp = !exp_ud && (fm != 2'd2) && ((a % (n * 4)) != 0);
        um = (en == 2'd2) && !nm;
        exp_data = d;
        exp_be   = '0;
        if (!exp_ud && !exp_gp) begin
            for (int j = 0; j < 16; j++) begin
                sel = !um || m[j];
                if (j < n) begin
                    if (sel) begin
                        exp_data[j*32 +: 32] = s[j*32 +: 32];
                        if (fm == 2'd1) exp_be[j*4 +: 4] = 4'hF;
                    end else if (fm != 2'd1 && z) begin
                        exp_data[j*32 +: 32] = 32'h0;
                    end
                end else if (fm != 2'd1 && en != 2'd0) begin
                    exp_data[j*32 +: 32] = 32'h0;
                end
            end
        end
    endtask

    function automatic string auto_tag(input logic [31:0] a, input logic [15:0] m,
                                       input logic nm, input logic [1:0] vl,
                                       input logic [1:0] fm, input logic [1:0] en,
                                       input logic [3:0] rs);
        int n;
        n = (vl == 2'd0) ? 4 : (vl == 2'd1) ? 8 : 16;
        if (exp_ud && fm != 2'd2 && (a % (n * 4)) != 0) return "R12";
        if (exp_ud && en != 2'd0 && rs != 4'hF) return "R8";
        if (exp_ud) return "R10";
        if (exp_gp) return "R7";
        if (en != 2'd2 && m != 16'hFFFF) return "R10";
        if (fm == 2'd1) return "R4";
        if (en == 2'd0) return "R6";
        if (en == 2'd2 && !nm) return "R3";
        if (vl != 2'd2) return "R5";
        return "R2";
    endfunction

    task automatic check_prev();
        if (pend) begin
            tests++;
            if (rsp_valid !== 1'b1 || rsp_data !== exp_data || rsp_byte_en !== exp_be
                || rsp_gp !== exp_gp || rsp_ud !== exp_ud) begin
                fails++;
                $display("FAIL %s: got valid=%0b gp=%0b ud=%0b be=%h data=%h expected valid=1 gp=%0b ud=%0b be=%h data=%h",
                         pend_tag, rsp_valid, rsp_gp, rsp_ud, rsp_byte_en, rsp_data,
                         exp_gp, exp_ud, exp_be, exp_data);
            end
        end
    endtask

    task automatic issue(input logic [511:0] s, input logic [511:0] d, input logic [31:0] a,
                         input logic [15:0] m, input logic nm, input logic z,
                         input logic [1:0] vl, input logic [1:0] fm, input logic [1:0] en,
                         input logic [3:0] rs, input string tag);
        @(negedge clk);
        check_prev();
        req_valid  = 1'b1;
        req_src    = s;
        req_dst    = d;
        req_addr   = a;
        req_mask   = m;
        req_nomask = nm;
        req_zero   = z;
        req_vlen   = vl;
        req_form   = fm;
        req_enc    = en;
        req_rsvd   = rs;
        model(s, d, a, m, nm, z, vl, fm, en, rs);
        pend_tag = (tag == "") ? auto_tag(a, m, nm, vl, fm, en, rs) : tag;
        pend = 1'b1;
    endtask

    task automatic idle_check();
        @(negedge clk);
        check_prev();
        req_valid = 1'b0;
        pend = 1'b0;
        @(negedge clk);
        tests++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R11: idle cycle valid=%0b expected 0", rsp_valid);
        end
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: run did not complete, expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] masks [4];
        logic [31:0] addrs [3];
        logic [3:0]  rsvds [2];
        int          seed;
        masks[0] = 16'hFFFF; masks[1] = 16'h0000; masks[2] = 16'hA5C3; masks[3] = 16'h0001;
        addrs[0] = 32'h0000_1000; addrs[1] = 32'h0000_1010; addrs[2] = 32'h0000_1024;
        rsvds[0] = 4'hF; rsvds[1] = 4'h7;
        seed = 1;

        repeat (3) @(negedge clk);
        tests++;
        if (rsp_valid !== 1'b0 || rsp_gp !== 1'b0 || rsp_ud !== 1'b0 || rsp_byte_en !== '0) begin
            fails++;
            $display("FAIL R11: reset state valid=%0b gp=%0b ud=%0b be=%h expected all zero",
                     rsp_valid, rsp_gp, rsp_ud, rsp_byte_en);
        end
        rst_n = 1'b1;

        // R9: signalling NaN and denormal payloads copied bit-exactly
        issue({16{32'h7F80_0001}}, '0, 32'h0, 16'hFFFF, 1'b1, 1'b0, 2'd2, 2'd2, 2'd2, 4'hF, "R9");
        issue({16{32'h0000_0003}}, {16{32'hFFFF_FFFF}}, 32'h40, 16'hFFFF, 1'b0, 1'b0, 2'd2, 2'd0, 2'd2, 4'hF, "R9");
        // R2: full-length EVEX copy with full mask
        issue(mkvec(32'h55), mkvec(32'hAA), 32'h3, 16'hFFFF, 1'b0, 1'b1, 2'd2, 2'd2, 2'd2, 4'hF, "R2");
        // R1: 128-bit EVEX store, all mask bits, upper lanes not enabled
        issue(mkvec(32'h11), mkvec(32'h22), 32'h10, 16'hFFFF, 1'b0, 1'b0, 2'd0, 2'd1, 2'd2, 4'hF, "R1");
        // R5: 256-bit VEX load clears upper half
        issue(mkvec(32'h33), mkvec(32'h44), 32'h20, 16'h0000, 1'b0, 1'b0, 2'd1, 2'd0, 2'd1, 4'hF, "R5");
        // R10: code value 3 in form, encoding and length
        issue(mkvec(32'h66), mkvec(32'h77), 32'h0, 16'hFFFF, 1'b1, 1'b0, 2'd0, 2'd3, 2'd2, 4'hF, "R10");
        issue(mkvec(32'h66), mkvec(32'h77), 32'h0, 16'hFFFF, 1'b1, 1'b0, 2'd0, 2'd0, 2'd3, 4'hF, "R10");
        issue(mkvec(32'h66), mkvec(32'h77), 32'h0, 16'hFFFF, 1'b1, 1'b0, 2'd3, 2'd0, 2'd2, 4'hF, "R10");
        // R8: legacy ignores reserved field
        issue(mkvec(32'h88), mkvec(32'h99), 32'h0, 16'h0000, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 4'h0, "R8");
        idle_check();

        for (int en = 0; en < 3; en++)
        for (int vl = 0; vl < 3; vl++)
        for (int fm = 0; fm < 3; fm++)
        for (int nm = 0; nm < 2; nm++)
        for (int z = 0; z < 2; z++)
        for (int mi = 0; mi < 4; mi++)
        for (int ai = 0; ai < 3; ai++)
        for (int ri = 0; ri < 2; ri++) begin
            seed++;
            issue(mkvec(seed * 32'h9E37), mkvec(seed * 32'h79B9 ^ 32'hDEAD_0000), addrs[ai],
                  masks[mi], nm[0], z[0], vl[1:0], fm[1:0], en[1:0], rsvds[ri], "");
        end
        idle_check();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule